// File: doc/BRIEF.md
# Integer 5/3 Lifting Wavelet Stage

This block computes one decomposition level of the reversible 5/3 integer wavelet on a stream of unsigned grayscale pixels. Samples arrive one per clock, qualified by a valid strobe. A line-end flag marks the last sample of each image line. The block treats samples at even positions of a line (counted from zero) as the even phase and the others as the odd phase. From these it forms two half-rate coefficient streams: a high-pass detail band and a low-pass approximation band.

For each odd sample, a prediction step subtracts the floored mean of its two even neighbours, which gives the detail. An update step then adds a rounded quarter of the two adjacent details to the even sample, which gives the approximation. All arithmetic is exact two's-complement integer arithmetic with floor division by arithmetic right shift, so negative intermediate values round toward minus infinity. At line edges, missing neighbours come from symmetric extension.

Lines are of even length, two or more, so the line-end flag always falls on an odd-phase sample. The pair for the final odd sample is therefore produced as soon as that sample arrives.

Top module: `dwt53_stage`

## Requirements
- R1: While reset is asserted, and after its release until the first pair is complete, `out_valid` is low and both coefficient outputs read zero.
- R2: For an odd sample o at line position 2k+1 that has a right even neighbour, the detail is d = o − floor((x[2k] + x[2k+2]) / 2). For example, 48 between 66 and 39 gives −4.
- R3: Negative sums are divided by floor, using a sign-replicating shift. For example, an even sample 39 with adjacent details −4 and 1 gives 39 + floor(−1/4) = 38, not 39.
- R4: The approximation for even sample e = x[2k] is s = e + floor((d_left + d_right + 2) / 4), where d_right is the detail at position 2k+1 and d_left is the detail at position 2k−1.
- R5: For the last odd sample of a line there is no right even neighbour. That neighbour is replaced by the left one, so d = o − x[N−2].
- R6: For the first even sample of a line there is no left detail. It is replaced by the right one, so s = x[0] + floor((2·d0 + 2) / 4).
- R7: A pair (`out_lo`, `out_hi`) with `out_valid` high appears in the cycle after the sample that completes it: either the next even sample x[2k+2], or the line-end odd sample. An odd sample without the line-end flag produces no output in the following cycle.
- R8: A cycle with `in_valid` low leaves the block's state unchanged and is followed by a cycle with `out_valid` low. Idle gaps inside a line do not change any coefficient.
- R9: A line of N samples yields exactly N/2 pairs, in line order. After the line-end flag the block restarts, so the next line again uses the R6 extension.
- R10: Coefficients are COEF_W = PIX_W + 2 bits, two's complement. Details lie in ±(2^PIX_W − 1) and approximations in [−2^(PIX_W−1), 2^PIX_W − 1 + 2^(PIX_W−1)], with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Sample qualifier |
| in_pix | input | PIX_W | Unsigned pixel sample |
| in_last | input | 1 | High with the final (odd-position) sample of a line |
| out_valid | output | 1 | Coefficient pair qualifier |
| out_lo | output | COEF_W | Signed approximation coefficient |
| out_hi | output | COEF_W | Signed detail coefficient |

## Verification
The bench drives two instances from the same stimulus. The first uses PIX_W = 4 (COEF_W = 6). At this size every combination of the first three samples of a four-sample line can be swept: 4096 lines that cover both edge extensions and every sign case of the floored divisions. The second uses the default PIX_W = 8. It carries the worked negative-value example with cycle-exact timing, full-scale alternating lines that push the coefficients to their range limits, long lines, short two-sample lines, and a line broken by idle gaps.

// File: rtl/dwt53_pkg.sv
package dwt53_pkg;

  typedef enum logic {
    PH_EVEN = 1'b0,
    PH_ODD  = 1'b1
  } phase_e;

  // Per-sample steering decided by the phase controller
  typedef struct packed {
    logic load_even;   // capture the sample as the held even value
    logic load_odd;    // capture the sample as the held odd value
    logic emit;        // a coefficient pair completes on this sample
    logic right_live;  // right even neighbour is the current sample
    logic first;       // no left detail yet in this line
  } ctl_t;

endpackage

// File: rtl/dwt53_ctrl.sv
module dwt53_ctrl
  import dwt53_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en,
  input  logic smp_last,
  output ctl_t ctl
);

  phase_e phase_q, phase_d;
  logic   pend_q,  pend_d;
  logic   first_q, first_d;

  // Next state, assuming a sample is accepted this cycle
  always_comb begin
    ctl       = '0;
    ctl.first = first_q;
    phase_d   = phase_q;
    pend_d    = pend_q;
    first_d   = first_q;
    if (phase_q == PH_EVEN) begin
      ctl.load_even  = 1'b1;
      ctl.emit       = pend_q;
      ctl.right_live = 1'b1;
      phase_d        = PH_ODD;
      pend_d         = 1'b0;
      if (pend_q) first_d = 1'b0;
    end else begin
      ctl.load_odd   = ~smp_last;
      ctl.emit       = smp_last;
      ctl.right_live = 1'b0;
      phase_d        = PH_EVEN;
      pend_d         = ~smp_last;
      if (smp_last) first_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_EVEN;
      pend_q  <= 1'b0;
      first_q <= 1'b1;
    end else if (smp_en) begin
      phase_q <= phase_d;
      pend_q  <= pend_d;
      first_q <= first_d;
    end
  end

endmodule

// File: rtl/dwt53_predict.sv
module dwt53_predict #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = PIX_W + 2
) (
  input  logic        [PIX_W-1:0]  even_l,
  input  logic        [PIX_W-1:0]  even_r,
  input  logic        [PIX_W-1:0]  odd,
  output logic signed [COEF_W-1:0] detail
);

  localparam int EXT_W = COEF_W - PIX_W;

  logic signed [COEF_W-1:0] sum_e;
  logic signed [COEF_W-1:0] half_e;

  always_comb begin
    sum_e  = $signed({{EXT_W{1'b0}}, even_l}) + $signed({{EXT_W{1'b0}}, even_r});
    half_e = sum_e >>> 1;
    detail = $signed({{EXT_W{1'b0}}, odd}) - half_e;
  end

endmodule

// File: rtl/dwt53_update.sv
module dwt53_update #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = PIX_W + 2
) (
  input  logic        [PIX_W-1:0]  even,
  input  logic signed [COEF_W-1:0] d_l,
  input  logic signed [COEF_W-1:0] d_r,
  output logic signed [COEF_W-1:0] approx
);

  localparam int EXT_W = COEF_W - PIX_W;
  localparam int ACC_W = COEF_W + 1;

  logic signed [ACC_W-1:0]  acc;
  logic signed [COEF_W-1:0] qtr;

  always_comb begin
    acc    = $signed({d_l[COEF_W-1], d_l}) + $signed({d_r[COEF_W-1], d_r})
           + $signed(ACC_W'(2));
    qtr    = COEF_W'(acc >>> 2);
    approx = $signed({{EXT_W{1'b0}}, even}) + qtr;
  end

endmodule

// File: rtl/dwt53_stage.sv
module dwt53_stage
  import dwt53_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = PIX_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic        [PIX_W-1:0]  in_pix,
  input  logic                     in_last,
  output logic                     out_valid,
  output logic signed [COEF_W-1:0] out_lo,
  output logic signed [COEF_W-1:0] out_hi
);

  localparam int SYNC_W = 2;

  // Reset: asserted asynchronously, released on the clock
  logic [SYNC_W-1:0] rst_pipe;
  logic              rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_W-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_W-1];

  ctl_t ctl;

  dwt53_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .smp_en   (in_valid),
    .smp_last (in_last),
    .ctl      (ctl)
  );

  logic        [PIX_W-1:0]  even_q, odd_q;
  logic signed [COEF_W-1:0] dprev_q;
  logic        [PIX_W-1:0]  odd_op, right_op;
  logic signed [COEF_W-1:0] d_now, d_left, s_now;
  logic                     even_en, odd_en, pair_en;

  always_comb begin
    odd_op   = ctl.right_live ? odd_q  : in_pix;
    right_op = ctl.right_live ? in_pix : even_q;   // symmetric extension at line end
    even_en  = in_valid & ctl.load_even;
    odd_en   = in_valid & ctl.load_odd;
    pair_en  = in_valid & ctl.emit;
  end

  dwt53_predict #(.PIX_W(PIX_W), .COEF_W(COEF_W)) u_predict (
    .even_l (even_q),
    .even_r (right_op),
    .odd    (odd_op),
    .detail (d_now)
  );

  assign d_left = ctl.first ? d_now : dprev_q;      // symmetric extension at line start

  dwt53_update #(.PIX_W(PIX_W), .COEF_W(COEF_W)) u_update (
    .even   (even_q),
    .d_l    (d_left),
    .d_r    (d_now),
    .approx (s_now)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      even_q  <= '0;
      odd_q   <= '0;
      dprev_q <= '0;
    end else begin
      if (even_en) even_q  <= in_pix;
      if (odd_en)  odd_q   <= in_pix;
      if (pair_en) dprev_q <= d_now;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      out_lo    <= '0;
      out_hi    <= '0;
    end else begin
      out_valid <= pair_en;
      if (pair_en) begin
        out_lo <= s_now;
        out_hi <= d_now;
      end
    end
  end

endmodule

// File: rtl/dwt53_stage_chk.sv
module dwt53_stage_chk #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = PIX_W + 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     in_last,
  input logic                     out_valid,
  input logic signed [COEF_W-1:0] out_lo,
  input logic signed [COEF_W-1:0] out_hi
);

  localparam int HI_MAX = (1 << PIX_W) - 1;
  localparam int LO_MIN = -(1 << (PIX_W - 1));
  localparam int LO_MAX = HI_MAX + (1 << (PIX_W - 1));

  logic line_start;
  logic pos_odd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_start <= 1'b1;
      pos_odd    <= 1'b0;
    end else if (in_valid) begin
      line_start <= in_last;
      pos_odd    <= in_last ? 1'b0 : ~pos_odd;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R8

  AST_LINE_END_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> out_valid);  // R5

  AST_ODD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pos_odd && !in_last) |=> !out_valid);  // R7

  AST_FIRST_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && line_start) |=> !out_valid);  // R9

  AST_HI_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_hi) <= HI_MAX && int'(out_hi) >= -HI_MAX));  // R10

  AST_LO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_lo) <= LO_MAX && int'(out_lo) >= LO_MIN));  // R10

endmodule

bind dwt53_stage dwt53_stage_chk #(.PIX_W(PIX_W), .COEF_W(COEF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_lo    (out_lo),
  .out_hi    (out_hi)
);

// File: tb/dwt53_stage_test.sv
`timescale 1ns/1ps
module dwt53_stage_test;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_last;
  logic [7:0] in_pix;

  logic a_ov, b_ov;
  logic signed [5:0] a_lo, a_hi;
  logic signed [9:0] b_lo, b_hi;

  int n_chk = 0;
  int n_err = 0;
  int lbuf[64];
  int qa_lo[$], qa_hi[$], qb_lo[$], qb_hi[$];

  always #2 clk = ~clk;

  dwt53_stage #(.PIX_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix[3:0]),
    .in_last(in_last), .out_valid(a_ov), .out_lo(a_lo), .out_hi(a_hi));

  dwt53_stage uut8 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .in_last(in_last), .out_valid(b_ov), .out_lo(b_lo), .out_hi(b_hi));

  always @(negedge clk) begin
    if (a_ov) begin qa_lo.push_back(int'(a_lo)); qa_hi.push_back(int'(a_hi)); end
    if (b_ov) begin qb_lo.push_back(int'(b_lo)); qb_hi.push_back(int'(b_hi)); end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fdiv(input int a, input int b);
    int q = a / b;
    if ((a % b != 0) && ((a < 0) != (b < 0))) q = q - 1;
    return q;
  endfunction

  task automatic put(input int v, input bit last);
    in_pix = v[7:0]; in_valid = 1'b1; in_last = last;
  endtask

  task automatic idle();
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic flush_q();
    qa_lo.delete(); qa_hi.delete(); qb_lo.delete(); qb_hi.delete();
  endtask

  task automatic compare_inst(input int w, input int n, input string ctx);
    int m = (1 << w) - 1;
    int kk = n / 2;
    int d[32];
    int s[32];
    int got_n;
    for (int k = 0; k < kk; k++) begin
      int e  = lbuf[2*k] & m;
      int er = (k + 1 < kk) ? (lbuf[2*k+2] & m) : e;
      d[k] = (lbuf[2*k+1] & m) - fdiv(e + er, 2);
    end
    for (int k = 0; k < kk; k++)
      s[k] = (lbuf[2*k] & m) + fdiv(((k == 0) ? d[0] : d[k-1]) + d[k] + 2, 4);
    got_n = (w == 4) ? qa_lo.size() : qb_lo.size();
    chk(got_n == kk, $sformatf("%s R9 pair count w=%0d", ctx, w), got_n, kk);
    for (int k = 0; k < kk && k < got_n; k++) begin
      int gl = (w == 4) ? qa_lo[k] : qb_lo[k];
      int gh = (w == 4) ? qa_hi[k] : qb_hi[k];
      chk(gh == d[k], $sformatf("%s %s detail w=%0d k=%0d", ctx,
          (k == kk - 1) ? "R5" : "R2", w, k), gh, d[k]);
      chk(gl == s[k], $sformatf("%s %s approx w=%0d k=%0d", ctx,
          (k == 0) ? "R6" : "R4", w, k), gl, s[k]);
    end
  endtask

  task automatic run_line(input int n, input bit gap, input string ctx);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      put(lbuf[i], i == n - 1);
      if (gap && i < n - 1) begin
        @(negedge clk); idle();
        @(negedge clk);
        chk(!b_ov && !a_ov, {ctx, " R8 idle gives no output"}, int'(b_ov), 0);
      end
    end
    @(negedge clk); idle();
    @(negedge clk);
    @(negedge clk);
    compare_inst(4, n, ctx);
    compare_inst(8, n, ctx);
    flush_q();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R7 watchdog actual=expired expected=completed");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int seed;
    rst_n = 1'b0; in_pix = '0; idle();
    repeat (3) @(negedge clk);
    chk(!a_ov && !b_ov, "R1 out_valid low in reset", int'(b_ov), 0);
    chk(b_lo == 0 && b_hi == 0, "R1 coefficients zero in reset", int'(b_lo), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!a_ov && !b_ov, "R1 out_valid low after release", int'(b_ov), 0);
    chk(a_lo == 0 && a_hi == 0, "R1 coefficients zero after release", int'(a_hi), 0);

    // Worked negative example with cycle-exact timing: 66 48 39 40
    @(negedge clk); put(66, 1'b0);
    @(negedge clk); put(48, 1'b0);
    @(negedge clk);
    chk(!b_ov, "R7 no output after non-last odd sample", int'(b_ov), 0);
    put(39, 1'b0);
    @(negedge clk);
    chk(b_ov, "R7 pair one cycle after completing even sample", int'(b_ov), 1);
    chk(b_hi == -4, "R2 detail 48 between 66 and 39", int'(b_hi), -4);
    chk(b_lo == 64, "R3 floor(-6/4) in first approximation", int'(b_lo), 64);
    put(40, 1'b1);
    @(negedge clk); idle();
    chk(b_ov, "R7 pair one cycle after line-end sample", int'(b_ov), 1);
    chk(b_hi == 1, "R5 last detail uses left even neighbour", int'(b_hi), 1);
    chk(b_lo == 38, "R3 39 + floor(-1/4)", int'(b_lo), 38);
    @(negedge clk);
    chk(!b_ov, "R8 idle cycle gives no output", int'(b_ov), 0);
    flush_q();

    // Near-exhaustive sweep of four-sample lines at PIX_W = 4
    for (int x0 = 0; x0 < 16; x0++)
      for (int x1 = 0; x1 < 16; x1++)
        for (int x2 = 0; x2 < 16; x2++) begin
          lbuf[0] = x0; lbuf[1] = x1; lbuf[2] = x2;
          lbuf[3] = (x0 * 5 + x1 * 3 + x2 + 7) % 16;
          run_line(4, 1'b0, "sweep R4");
        end

    // Two-sample lines: both extensions at once
    lbuf[0] = 200; lbuf[1] = 10;  run_line(2, 1'b0, "short R6");
    lbuf[0] = 3;   lbuf[1] = 250; run_line(2, 1'b0, "short R5");

    // Full-scale alternation toward the coefficient range limits
    for (int i = 0; i < 6; i++) lbuf[i] = (i % 2) ? 255 : 0;
    run_line(6, 1'b0, "extremes R10");
    for (int i = 0; i < 6; i++) lbuf[i] = (i % 2) ? 0 : 255;
    run_line(6, 1'b0, "extremes R10");
    for (int i = 0; i < 6; i++) lbuf[i] = (i % 4 == 0) ? 255 : ((i % 2) ? 255 : 0);
    run_line(6, 1'b0, "extremes R10");

    // Long pseudo-random lines, back to back
    seed = 12345;
    for (int l = 0; l < 20; l++) begin
      for (int i = 0; i < 16; i++) begin
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        lbuf[i] = (seed >> 8) & 255;
      end
      run_line(16, 1'b0, "long R9");
    end

    // Line with idle gaps between samples
    for (int i = 0; i < 8; i++) lbuf[i] = (i * 73 + 19) & 255;
    run_line(8, 1'b1, "gap R8");

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule